// File: doc/BRIEF.md
# Pattern Recognizer and Acquisition Trigger Selector

This block watches a sampled 16-bit data word and a one-bit qualifier. It compares them against a programmable three-state pattern, in which every position is either required high, required low or ignored. When a sample matches, it raises a one-clock word-hit pulse on a dedicated output, so that other instruments can trigger from it. The same block also picks the acquisition trigger from one of four sources. These are an external trigger line, a rising edge on data bit 0, the word recognizer and a debounced push button.

The trigger path is a small arming state machine with three states: `ST_IDLE`, `ST_ARMED` and `ST_FIRED`. Its transitions are:
- `ST_IDLE` to `ST_ARMED` on `arm_req` (arm).
- `ST_ARMED` to `ST_FIRED` when the selected source produces an event (fire).
- `ST_FIRED` to `ST_ARMED` on `arm_req` (re-arm).

On the fire transition `trig_out` pulses for one clock. In every other case it stays low. Control of the acquisition memory after the trigger is handled elsewhere.

Top module: `word_trigger_sel`

## Requirements
- R1: Pattern bit i matches when `pat_care[i]` is 0, whatever the data bit is. When `pat_care[i]` is 1, it matches only if `data_in[i]` equals `pat_val[i]`. With all care bits at 0, every strobed sample is a hit unless the qualifier term fails.
- R2: The qualifier term matches when `qual_care` is 0. When `qual_care` is 1, it matches only if `qual_in` equals `qual_val`. A word hit needs all 16 bit terms and the qualifier term to match.
- R3: `word_match_out` is high for exactly the one clock that follows a clock edge where `sample_stb` was 1 and the word matched. It is never high after an edge without a strobe.
- R4: `src_sel` encodes the trigger source as follows: 0 is external, 1 is channel-0 edge, 2 is word recognizer and 3 is manual push. Only the source selected at the event's cycle can fire the trigger. With source 2, `trig_out` rises one clock after `word_match_out`.
- R5: A channel-0 event occurs one clock after a strobe edge where `data_in[0]` is 1 and bit 0 was 0 at the previous strobe. The first strobe after reset never produces this event.
- R6: An external event occurs one clock after an edge where `ext_trig` is 1, provided it was 0 at the previous edge.
- R7: The push input passes through two synchronizer flops. It must then hold a new level for `DEB_CYCLES` consecutive clocks before that level is accepted. Each accepted press gives exactly one manual event. A press shorter than `DEB_CYCLES` gives none.
- R8: In `ST_ARMED`, the first event from the selected source sets `trig_out` high for exactly one clock, starting on the clock after the event.
- R9: In `ST_FIRED`, events are ignored until `arm_req` is seen. If `arm_req` and an event arrive in the same cycle while in `ST_FIRED`, the block re-arms and does not fire.
- R10: Reset (`rst_n` low) puts the block in `ST_IDLE` with both outputs low. No trigger is produced until the first `arm_req`, even if word hits occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | Sample strobe; data and qualifier are valid this cycle |
| data_in | input | 16 | Sampled data word |
| qual_in | input | 1 | Sampled qualifier |
| pat_val | input | 16 | Required value per data bit |
| pat_care | input | 16 | Care mask per data bit (1 = compare) |
| qual_val | input | 1 | Required qualifier value |
| qual_care | input | 1 | Qualifier care bit |
| src_sel | input | 2 | Trigger source: 0 ext, 1 ch0 edge, 2 word, 3 manual |
| ext_trig | input | 1 | External trigger line |
| push_btn | input | 1 | Raw manual push input |
| arm_req | input | 1 | Arm / re-arm request |
| trig_out | output | 1 | One-clock acquisition trigger pulse |
| word_match_out | output | 1 | One-clock word-hit pulse for external instruments |

## Verification
Two functions can fall in the same cycle: a re-arm request and a source event. The bench drives `arm_req` at random alongside strobes that often match, bit-0 toggles and external edges, so both orders and the same-cycle case happen many times from `ST_ARMED` and from `ST_FIRED`. A bench model of the arming rules predicts each cycle whether `trig_out` must fire. In that model an event in `ST_ARMED` wins, and a simultaneous arm in `ST_FIRED` only re-arms. The model also predicts each cycle's `word_match_out`, independently of whether a trigger fires.

// File: rtl/wts_pkg.sv
package wts_pkg;
    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_CH0  = 2'd1,
        SRC_WORD = 2'd2,
        SRC_MAN  = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } arm_state_e;
endpackage

// File: rtl/wts_word_match.sv
module wts_word_match #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [WIDTH-1:0] data,
    input  logic             qual,
    input  logic [WIDTH-1:0] val,
    input  logic [WIDTH-1:0] care,
    input  logic             q_val,
    input  logic             q_care,
    output logic             hit
);
    logic [WIDTH-1:0] lane_ok;
    logic             q_ok;

    // one ternary comparator per data lane
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        assign lane_ok[i] = ~care[i] | ~(data[i] ^ val[i]);
    end

    assign q_ok = ~q_care | ~(qual ^ q_val);

    always_ff @(posedge clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= stb & q_ok & (&lane_ok);
    end
endmodule

// File: rtl/wts_edge_src.sv
module wts_edge_src (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic bit0,
    input  logic ext,
    output logic ch0_evt,
    output logic ext_evt
);
    logic prev0;
    logic seen;
    logic ext_prev;

    // channel-0 edge is judged between consecutive strobed samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev0   <= 1'b0;
            seen    <= 1'b0;
            ch0_evt <= 1'b0;
        end else begin
            ch0_evt <= stb & seen & bit0 & ~prev0;
            if (stb) begin
                prev0 <= bit0;
                seen  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_prev <= 1'b0;
            ext_evt  <= 1'b0;
        end else begin
            ext_prev <= ext;
            ext_evt  <= ext & ~ext_prev;
        end
    end
endmodule

// File: rtl/wts_push_filter.sv
module wts_push_filter #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic press
);
    localparam int CW  = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(DEB_CYCLES - 1);

    logic          s1, s2;
    logic          level;
    logic [CW-1:0] cnt;
    logic          accept;

    assign accept = (s2 != level) && (cnt == LIM);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= raw;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            cnt   <= '0;
            press <= 1'b0;
        end else begin
            press <= accept & s2;
            if (s2 == level) begin
                cnt <= '0;
            end else if (accept) begin
                level <= s2;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/word_trigger_sel.sv
module word_trigger_sel
    import wts_pkg::*;
#(
    parameter int WIDTH      = 16,
    parameter int DEB_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_stb,
    input  logic [WIDTH-1:0] data_in,
    input  logic             qual_in,
    input  logic [WIDTH-1:0] pat_val,
    input  logic [WIDTH-1:0] pat_care,
    input  logic             qual_val,
    input  logic             qual_care,
    input  logic [1:0]       src_sel,
    input  logic             ext_trig,
    input  logic             push_btn,
    input  logic             arm_req,
    output logic             trig_out,
    output logic             word_match_out
);
    logic       word_hit;
    logic       ch0_evt;
    logic       ext_evt;
    logic       man_evt;
    logic       sel_evt;
    arm_state_e state_q, state_d;

    wts_word_match #(.WIDTH(WIDTH)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (sample_stb),
        .data   (data_in),
        .qual   (qual_in),
        .val    (pat_val),
        .care   (pat_care),
        .q_val  (qual_val),
        .q_care (qual_care),
        .hit    (word_hit)
    );

    wts_edge_src u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (sample_stb),
        .bit0    (data_in[0]),
        .ext     (ext_trig),
        .ch0_evt (ch0_evt),
        .ext_evt (ext_evt)
    );

    wts_push_filter #(.DEB_CYCLES(DEB_CYCLES)) u_push (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (push_btn),
        .press (man_evt)
    );

    assign word_match_out = word_hit;

    always_comb begin
        unique case (trig_src_e'(src_sel))
            SRC_EXT:  sel_evt = ext_evt;
            SRC_CH0:  sel_evt = ch0_evt;
            SRC_WORD: sel_evt = word_hit;
            SRC_MAN:  sel_evt = man_evt;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm_req) state_d = ST_ARMED;
            ST_ARMED: if (sel_evt) state_d = ST_FIRED;
            ST_FIRED: if (arm_req) state_d = ST_ARMED;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) trig_out <= 1'b0;
        else        trig_out <= (state_q == ST_ARMED) && sel_evt;
    end
endmodule

// File: rtl/wts_checker.sv
module wts_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sample_stb,
    input logic [15:0] data_in,
    input logic        qual_in,
    input logic [15:0] pat_val,
    input logic [15:0] pat_care,
    input logic        qual_val,
    input logic        qual_care,
    input logic [1:0]  src_sel,
    input logic        ext_trig,
    input logic        trig_out,
    input logic        word_match_out
);
    AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        word_match_out |-> $past(sample_stb)); // R3

    AST_HIT_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        word_match_out |-> ($past((data_in ^ pat_val) & pat_care) == 16'd0)); // R1

    AST_HIT_QUALIFIER: assert property (@(posedge clk) disable iff (!rst_n)
        word_match_out |-> ($past(!qual_care || (qual_in == qual_val)))); // R2

    AST_WORD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && $past(src_sel) == 2'd2) |-> $past(word_match_out)); // R4

    AST_EXT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && $past(src_sel) == 2'd0) |-> $past(ext_trig, 2)); // R6

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out); // R8
endmodule

bind word_trigger_sel wts_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_stb     (sample_stb),
    .data_in        (data_in),
    .qual_in        (qual_in),
    .pat_val        (pat_val),
    .pat_care       (pat_care),
    .qual_val       (qual_val),
    .qual_care      (qual_care),
    .src_sel        (src_sel),
    .ext_trig       (ext_trig),
    .trig_out       (trig_out),
    .word_match_out (word_match_out)
);

// File: tb/word_trigger_sel_tb.sv
module word_trigger_sel_tb;
    localparam int DEB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic [15:0] data_in = '0;
    logic        qual_in = 1'b0;
    logic [15:0] pat_val = '0;
    logic [15:0] pat_care = '0;
    logic        qual_val = 1'b0;
    logic        qual_care = 1'b0;
    logic [1:0]  src_sel = 2'd2;
    logic        ext_trig = 1'b0;
    logic        push_btn = 1'b0;
    logic        arm_req = 1'b0;
    logic        trig_out;
    logic        word_match_out;

    int n_vec = 0;
    int n_bad = 0;

    // bench model state
    bit m_armed = 0, m_prev0 = 0, m_valid = 0, m_extprev = 0;
    bit e_wm = 0, e_ch0 = 0, e_ext = 0, e_trig = 0;

    always #5 clk = ~clk;

    word_trigger_sel #(.WIDTH(16), .DEB_CYCLES(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .data_in(data_in),
        .qual_in(qual_in), .pat_val(pat_val), .pat_care(pat_care),
        .qual_val(qual_val), .qual_care(qual_care), .src_sel(src_sel),
        .ext_trig(ext_trig), .push_btn(push_btn), .arm_req(arm_req),
        .trig_out(trig_out), .word_match_out(word_match_out)
    );

    function automatic bit f_match(logic [15:0] d, logic q);
        return (((d ^ pat_val) & pat_care) == 16'd0) && (!qual_care || (q == qual_val));
    endfunction

    task automatic chk(logic act, logic exp, string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string trig_tag();
        case (src_sel)
            2'd0:    return "R6 R8 R9 ext trigger";
            2'd1:    return "R5 R8 R9 ch0 trigger";
            2'd2:    return "R4 R8 R9 word trigger";
            default: return "R7 R8 manual trigger";
        endcase
    endfunction

    // entered at a negedge; drives inputs, predicts, checks at next negedge
    task automatic mstep(bit stb, logic [15:0] d, bit q, bit arm, bit ext);
        bit evt, n_trig, n_wm, n_ch0, n_ext;
        string tg;
        sample_stb = stb; data_in = d; qual_in = q; arm_req = arm; ext_trig = ext;
        case (src_sel)
            2'd0:    evt = e_ext;
            2'd1:    evt = e_ch0;
            2'd2:    evt = e_wm;
            default: evt = 1'b0;
        endcase
        tg = trig_tag();
        n_trig = m_armed && evt;
        if (m_armed) begin
            if (evt) m_armed = 0;
        end else if (arm) m_armed = 1;
        n_wm  = stb && f_match(d, q);
        n_ch0 = stb && m_valid && d[0] && !m_prev0;
        if (stb) begin m_prev0 = d[0]; m_valid = 1; end
        n_ext = ext && !m_extprev;
        m_extprev = ext;
        @(negedge clk);
        e_wm = n_wm; e_ch0 = n_ch0; e_ext = n_ext; e_trig = n_trig;
        chk(word_match_out, e_wm, "R1 R2 R3 word hit");
        chk(trig_out, e_trig, tg);
    endtask

    int man_cnt;
    task automatic man_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (trig_out) man_cnt++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bit stb, ext, arm;
        logic [15:0] d;
        bit q;
        void'($urandom(32'h5eed_2024));
        repeat (3) @(negedge clk);
        chk(trig_out, 1'b0, "R10 reset trig");
        chk(word_match_out, 1'b0, "R10 reset hit");
        rst_n = 1'b1;
        @(negedge clk);
        chk(trig_out, 1'b0, "R10 after reset trig");

        // R10: matches while idle give hits but no trigger
        pat_val = 16'hA5C3; pat_care = 16'hFFFF; qual_care = 1'b1; qual_val = 1'b1;
        src_sel = 2'd2;
        mstep(1, 16'hA5C3, 1, 0, 0);
        mstep(1, 16'hA5C3, 1, 0, 0);
        // R2: qualifier mismatch blocks the hit
        mstep(1, 16'hA5C3, 0, 0, 0);
        // R3: no strobe, no hit
        mstep(0, 16'hA5C3, 1, 0, 0);
        // R1: all don't-care
        pat_care = 16'h0000; qual_care = 1'b0;
        mstep(1, 16'h1234, 0, 0, 0);
        // R9: arm, fire, then further hits ignored
        mstep(0, 16'h0, 0, 1, 0);
        mstep(1, 16'h0, 0, 0, 0);
        mstep(0, 16'h0, 0, 0, 0);
        mstep(1, 16'h0, 0, 0, 0);
        mstep(1, 16'h0, 0, 0, 0);
        mstep(0, 16'h0, 0, 0, 0);
        mstep(0, 16'h0, 0, 0, 0);

        // R7: manual source
        src_sel = 2'd3;
        arm_req = 1'b1; @(negedge clk); arm_req = 1'b0;
        man_cnt = 0;
        push_btn = 1'b1; man_cycles(DEB + 10);
        push_btn = 1'b0; man_cycles(DEB + 10);
        chk(man_cnt == 1, 1'b1, "R7 long press one trigger");
        arm_req = 1'b1; @(negedge clk); arm_req = 1'b0;
        man_cnt = 0;
        push_btn = 1'b1; man_cycles(3);
        push_btn = 1'b0; man_cycles(DEB + 10);
        chk(man_cnt == 0, 1'b1, "R7 short glitch ignored");
        m_armed = 1; e_wm = 0; e_ch0 = 0; e_ext = 0; e_trig = 0;

        // constrained random batches
        for (int b = 0; b < 40; b++) begin
            pat_val   = 16'($urandom);
            pat_care  = (b % 8 == 0) ? 16'h0000 : 16'($urandom);
            qual_val  = 1'($urandom);
            qual_care = 1'($urandom);
            src_sel   = 2'($urandom_range(0, 2));
            for (int c = 0; c < 250; c++) begin
                stb = ($urandom_range(0, 3) != 0);
                if ($urandom_range(0, 1) == 0)
                    d = pat_val ^ (16'($urandom) & ~pat_care);
                else
                    d = 16'($urandom);
                q   = ($urandom_range(0, 3) != 0) ? qual_val : 1'($urandom);
                arm = ($urandom_range(0, 11) == 0);
                ext = ($urandom_range(0, 5) == 0);
                mstep(stb, d, q, arm, ext);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule